// File: doc/BRIEF.md
# Effective Address Context Qualifier

This block sits in front of an address translation engine. For every access it takes a 64-bit effective address, the access type (instruction fetch, data load or data store), the hypervisor state and the two relocation flags, and the current partition, process and real-mode offset registers. It decides what happens to the access next.

A hypervisor access with relocation off needs no table walk. The block forms the real address directly from the effective address and the real-mode offset. Any other access goes through the quadrant rules. The quadrant is the top two bits of the address. Together with the hypervisor state, it selects the partition ID and process ID that the later walk must use. It can also find the quadrant illegal, and then it reports a segment fault with its kind and the captured fault address.

Requests use a valid/ready handshake. Each accepted request produces one registered response, marked by a single-cycle valid pulse. The response fields hold their values until the next accepted request.

Top module: `ea_ctx_qualifier`

## Requirements
- R1: With the hypervisor flag set and translation needed, quadrant 0 (EA[63:62]=00) gives partition ID 0 and the process register. Quadrant 1 (01) gives the partition register and the process register.
- R2: With the hypervisor flag set and translation needed, quadrant 2 (10) gives the partition register and process ID 0. Quadrant 3 (11) gives partition ID 0 and process ID 0.
- R3: With the hypervisor flag clear, quadrant 0 gives the partition register and the process register. Quadrant 3 gives the partition register and process ID 0.
- R4: With the hypervisor flag clear, quadrants 1 and 2 are illegal. The response then has rsp_segfault=1, rsp_xlate=0 and rsp_real=0, and both IDs read 0.
- R5: Fault kind encoding is 0 none, 1 instruction segment, 2 data segment. A segment fault on a fetch (req_acc=0) reports kind 1 with fault address 0. On a load (1) or store (2) it reports kind 2 with the effective address as fault address. Non-faulting responses report kind 0 and fault address 0.
- R6: A hypervisor access with relocation off is a real-mode response (rsp_real=1). Its real address is the effective address with bits 63:60 cleared. The real-mode offset is ORed in only when EA bit 63 is 0. The IDs read 0, and no quadrant check is made.
- R7: Relocation comes from the instruction-relocate flag when req_acc=0 and from the data-relocate flag otherwise; req_acc=3 counts as a load. Every response that is neither real-mode nor a fault has rsp_xlate=1 and real address 0.
- R8: A request is accepted when req_valid and req_ready are both high. rsp_valid is high for exactly the one cycle after acceptance. req_ready is low during that cycle. The response fields hold their values until the next acceptance.
- R9: After reset, rsp_valid is 0, req_ready is 1, and all response fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_ea | input | 64 | Effective address |
| req_acc | input | 2 | Access type: 0 fetch, 1 load, 2 store |
| hv_mode | input | 1 | Hypervisor state |
| inst_reloc | input | 1 | Instruction relocation enable |
| data_reloc | input | 1 | Data relocation enable |
| part_reg | input | 12 | Current partition ID register |
| proc_reg | input | 20 | Current process ID register |
| rmo_reg | input | 64 | Real-mode offset register |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_xlate | output | 1 | Access must be translated with the given IDs |
| rsp_real | output | 1 | Real address formed directly |
| rsp_segfault | output | 1 | Illegal quadrant |
| rsp_part_id | output | 12 | Selected partition ID |
| rsp_proc_id | output | 20 | Selected process ID |
| rsp_real_addr | output | 64 | Real address for the real-mode path |
| rsp_fault_kind | output | 2 | Fault kind code |
| rsp_fault_addr | output | 64 | Captured fault address |

## Verification
The assertions check on every cycle that the response strobe lasts one cycle and follows each acceptance. They also check that exactly one outcome flag is set with each strobe, that an instruction segment fault never carries an address, and that real-mode responses with EA bit 63 set carry the masked address. Only the bench scenarios can show that each quadrant and mode picks the right registers. The same holds for the offset rule on the bit-63-clear path, for choosing the relocation flag by access type, and for the fields holding between responses. For these, the bench walks every quadrant, mode and access type while the register values change.

// File: rtl/ea_ctx_pkg.sv
package ea_ctx_pkg;
   localparam logic [1:0] ACC_FETCH = 2'd0;
   localparam logic [1:0] ACC_LOAD  = 2'd1;
   localparam logic [1:0] ACC_STORE = 2'd2;

   typedef enum logic [1:0] {
      FK_NONE = 2'd0,
      FK_ISEG = 2'd1,
      FK_DSEG = 2'd2
   } fault_kind_e;

   localparam logic [1:0] Q_USER   = 2'd0;
   localparam logic [1:0] Q_HVUSER = 2'd1;
   localparam logic [1:0] Q_HVOS   = 2'd2;
   localparam logic [1:0] Q_OS     = 2'd3;
endpackage

// File: rtl/ea_quadrant_sel.sv
module ea_quadrant_sel #(
   parameter int PART_W = 12,
   parameter int PROC_W = 20
) (
   input  logic              hv,
   input  logic [1:0]        quad,
   input  logic [PART_W-1:0] part_reg,
   input  logic [PROC_W-1:0] proc_reg,
   output logic              illegal,
   output logic [PART_W-1:0] part_id,
   output logic [PROC_W-1:0] proc_id
);
   import ea_ctx_pkg::*;

   always_comb begin
      illegal = 1'b0;
      part_id = '0;
      proc_id = '0;
      if (hv) begin
         unique case (quad)
            Q_USER:   proc_id = proc_reg;
            Q_HVUSER: begin part_id = part_reg; proc_id = proc_reg; end
            Q_HVOS:   part_id = part_reg;
            default:  ;
         endcase
      end else begin
         unique case (quad)
            Q_USER:  begin part_id = part_reg; proc_id = proc_reg; end
            Q_OS:    part_id = part_reg;
            default: illegal = 1'b1;
         endcase
      end
   end
endmodule

// File: rtl/ea_realmode_addr.sv
module ea_realmode_addr #(
   parameter int EA_W   = 64,
   parameter int RM_CLR = 4
) (
   input  logic [EA_W-1:0] ea,
   input  logic [EA_W-1:0] rmo,
   output logic [EA_W-1:0] real_addr
);
   localparam int KEEP_W = EA_W - RM_CLR;
   logic [EA_W-1:0] masked;

   generate
      if (RM_CLR == 0) begin : g_pass
         assign masked = ea;
      end else begin : g_clear
         assign masked = {{RM_CLR{1'b0}}, ea[KEEP_W-1:0]};
      end
   endgenerate

   assign real_addr = ea[EA_W-1] ? masked : (masked | rmo);
endmodule

// File: rtl/ea_fault_fmt.sv
module ea_fault_fmt #(
   parameter int EA_W = 64
) (
   input  logic            illegal,
   input  logic [1:0]      acc,
   input  logic [EA_W-1:0] ea,
   output logic [1:0]      kind,
   output logic [EA_W-1:0] fault_addr
);
   import ea_ctx_pkg::*;

   always_comb begin
      kind       = FK_NONE;
      fault_addr = '0;
      if (illegal) begin
         if (acc == ACC_FETCH) begin
            kind = FK_ISEG;
         end else begin
            kind       = FK_DSEG;
            fault_addr = ea;
         end
      end
   end
endmodule

// File: rtl/ea_ctx_qualifier.sv
module ea_ctx_qualifier #(
   parameter int EA_W   = 64,
   parameter int PART_W = 12,
   parameter int PROC_W = 20,
   parameter int RM_CLR = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [EA_W-1:0]   req_ea,
   input  logic [1:0]        req_acc,
   input  logic              hv_mode,
   input  logic              inst_reloc,
   input  logic              data_reloc,
   input  logic [PART_W-1:0] part_reg,
   input  logic [PROC_W-1:0] proc_reg,
   input  logic [EA_W-1:0]   rmo_reg,
   output logic              rsp_valid,
   output logic              rsp_xlate,
   output logic              rsp_real,
   output logic              rsp_segfault,
   output logic [PART_W-1:0] rsp_part_id,
   output logic [PROC_W-1:0] rsp_proc_id,
   output logic [EA_W-1:0]   rsp_real_addr,
   output logic [1:0]        rsp_fault_kind,
   output logic [EA_W-1:0]   rsp_fault_addr
);
   import ea_ctx_pkg::*;

   localparam int QHI = EA_W - 1;
   localparam int QLO = EA_W - 2;

   generate
      if (EA_W < 8)             begin : g_bad_ea   $error("EA_W too small");   end
      if (RM_CLR >= EA_W)       begin : g_bad_clr  $error("RM_CLR too wide");  end
      if (PART_W < 1 || PROC_W < 1) begin : g_bad_id $error("ID width zero"); end
   endgenerate

   logic              reloc, real_path, accept;
   logic              q_illegal;
   logic [PART_W-1:0] q_part;
   logic [PROC_W-1:0] q_proc;
   logic [EA_W-1:0]   rm_addr, f_addr;
   logic [1:0]        f_kind;

   assign reloc     = (req_acc == ACC_FETCH) ? inst_reloc : data_reloc;
   assign real_path = hv_mode && !reloc;
   assign req_ready = !rsp_valid;
   assign accept    = req_valid && req_ready;

   ea_quadrant_sel #(.PART_W(PART_W), .PROC_W(PROC_W)) u_quad (
      .hv       (hv_mode),
      .quad     (req_ea[QHI:QLO]),
      .part_reg (part_reg),
      .proc_reg (proc_reg),
      .illegal  (q_illegal),
      .part_id  (q_part),
      .proc_id  (q_proc)
   );

   ea_realmode_addr #(.EA_W(EA_W), .RM_CLR(RM_CLR)) u_real (
      .ea        (req_ea),
      .rmo       (rmo_reg),
      .real_addr (rm_addr)
   );

   ea_fault_fmt #(.EA_W(EA_W)) u_fault (
      .illegal    (q_illegal && !real_path),
      .acc        (req_acc),
      .ea         (req_ea),
      .kind       (f_kind),
      .fault_addr (f_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid      <= 1'b0;
         rsp_xlate      <= 1'b0;
         rsp_real       <= 1'b0;
         rsp_segfault   <= 1'b0;
         rsp_part_id    <= '0;
         rsp_proc_id    <= '0;
         rsp_real_addr  <= '0;
         rsp_fault_kind <= FK_NONE;
         rsp_fault_addr <= '0;
      end else begin
         rsp_valid <= accept;
         if (accept) begin
            rsp_real       <= real_path;
            rsp_segfault   <= !real_path && q_illegal;
            rsp_xlate      <= !real_path && !q_illegal;
            rsp_part_id    <= real_path ? '0 : q_part;
            rsp_proc_id    <= real_path ? '0 : q_proc;
            rsp_real_addr  <= real_path ? rm_addr : '0;
            rsp_fault_kind <= f_kind;
            rsp_fault_addr <= f_addr;
         end
      end
   end

   // R8: an accepted request yields the strobe on the next cycle
   a_r8_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> rsp_valid);
   // R8: the strobe never lasts two cycles
   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   // R4: exactly one outcome per response
   a_r4_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ($countones({rsp_xlate, rsp_real, rsp_segfault}) == 1));
   // R5: instruction segment faults carry no address
   a_r5_iseg_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault_kind == FK_ISEG) |-> (rsp_fault_addr == '0));
   // R6: bit 63 set means the offset is not applied
   a_r6_no_offset_high: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_real && $past(req_ea[QHI])) |->
      (rsp_real_addr == {{RM_CLR{1'b0}}, $past(req_ea[EA_W-RM_CLR-1:0])}));
   // R2: hypervisor quadrant 3 translation clears both IDs
   a_r2_hv_q3_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_xlate && $past(hv_mode) && $past(req_ea[QHI:QLO]) == 2'b11)
      |-> (rsp_part_id == '0 && rsp_proc_id == '0));
endmodule

// File: tb/ea_ctx_qualifier_tb.sv
module ea_ctx_qualifier_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [63:0] req_ea = '0;
   logic [1:0]  req_acc = '0;
   logic        hv_mode = 1'b0, inst_reloc = 1'b0, data_reloc = 1'b0;
   logic [11:0] part_reg = '0;
   logic [19:0] proc_reg = '0;
   logic [63:0] rmo_reg = '0;
   logic        rsp_valid, rsp_xlate, rsp_real, rsp_segfault;
   logic [11:0] rsp_part_id;
   logic [19:0] rsp_proc_id;
   logic [63:0] rsp_real_addr, rsp_fault_addr;
   logic [1:0]  rsp_fault_kind;

   int compared = 0, mismatched = 0;

   always #10 clk = ~clk;

   ea_ctx_qualifier u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_ea(req_ea), .req_acc(req_acc), .hv_mode(hv_mode),
      .inst_reloc(inst_reloc), .data_reloc(data_reloc),
      .part_reg(part_reg), .proc_reg(proc_reg), .rmo_reg(rmo_reg),
      .rsp_valid(rsp_valid), .rsp_xlate(rsp_xlate), .rsp_real(rsp_real),
      .rsp_segfault(rsp_segfault), .rsp_part_id(rsp_part_id),
      .rsp_proc_id(rsp_proc_id), .rsp_real_addr(rsp_real_addr),
      .rsp_fault_kind(rsp_fault_kind), .rsp_fault_addr(rsp_fault_addr)
   );

   // reference state
   bit          m_valid = 0;
   bit          m_x = 0, m_r = 0, m_f = 0;
   logic [11:0] m_part = '0;
   logic [19:0] m_proc = '0;
   logic [63:0] m_real = '0, m_faddr = '0;
   logic [1:0]  m_kind = '0;
   string       m_tag = "R9";

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp, input string what);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic model_step();
      bit use_reloc;
      int q;
      if (req_valid && !m_valid) begin
         m_valid   = 1;
         use_reloc = (req_acc == 2'd0) ? inst_reloc : data_reloc;
         q         = int'(req_ea[63:62]);
         m_part = '0; m_proc = '0; m_real = '0; m_faddr = '0; m_kind = 2'd0;
         m_x = 0; m_r = 0; m_f = 0;
         if (hv_mode && !use_reloc) begin
            m_r = 1; m_tag = "R6";
            m_real = req_ea & 64'h0FFF_FFFF_FFFF_FFFF;
            if (req_ea[63] == 1'b0) m_real = m_real | rmo_reg;
         end else if (hv_mode) begin
            m_x = 1;
            m_tag = (q < 2) ? "R1" : "R2";
            if (q == 1 || q == 2) m_part = part_reg;
            if (q == 0 || q == 1) m_proc = proc_reg;
         end else if (q == 1 || q == 2) begin
            m_f = 1; m_tag = "R4";
            if (req_acc == 2'd0) m_kind = 2'd1;
            else begin m_kind = 2'd2; m_faddr = req_ea; end
         end else begin
            m_x = 1; m_tag = "R3";
            m_part = part_reg;
            if (q == 0) m_proc = proc_reg;
         end
      end else begin
         m_valid = 0;
      end
   endtask

   // compare every cycle away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R8", {63'd0, rsp_valid}, {63'd0, m_valid}, "rsp_valid");
         chk("R8", {63'd0, req_ready}, {63'd0, !m_valid}, "req_ready");
         chk(m_tag, {61'd0, rsp_xlate, rsp_real, rsp_segfault}, {61'd0, m_x, m_r, m_f}, "outcome R7");
         chk(m_tag, {52'd0, rsp_part_id}, {52'd0, m_part}, "part_id");
         chk(m_tag, {44'd0, rsp_proc_id}, {44'd0, m_proc}, "proc_id");
         chk(m_tag, rsp_real_addr, m_real, "real_addr");
         chk(m_f ? "R5" : m_tag, {62'd0, rsp_fault_kind}, {62'd0, m_kind}, "fault_kind");
         chk(m_f ? "R5" : m_tag, rsp_fault_addr, m_faddr, "fault_addr");
         model_step();
      end
   end

   task automatic send(input logic [63:0] ea, input logic [1:0] acc, input bit hv, input bit ir, input bit dr);
      req_ea = ea; req_acc = acc; hv_mode = hv; inst_reloc = ir; data_reloc = dr;
      req_valid = 1'b1;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   initial begin : watchdog
      #(20 * 150000);
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk("R9", {63'd0, rsp_valid}, 64'd0, "reset rsp_valid");
      chk("R9", {63'd0, req_ready}, 64'd1, "reset req_ready");
      chk("R9", rsp_real_addr | rsp_fault_addr, 64'd0, "reset addrs");
      @(posedge clk); #1;
      part_reg = 12'hA5C; proc_reg = 20'h3_1F2E; rmo_reg = 64'h0000_0040_0000_0000;
      // every quadrant, mode, access type and relocation setting (R1..R7)
      for (int hv = 0; hv < 2; hv++)
         for (int q = 0; q < 4; q++)
            for (int a = 0; a < 4; a++)
               for (int rl = 0; rl < 4; rl++)
                  send({q[1:0], 62'h0123_4567_89AB_CDE} ^ {2'b00, 12'(a * 7), 50'd0},
                       a[1:0], hv[0], rl[0], rl[1]);
      // R6: offset applied only with bit 63 clear
      send(64'h7FFF_0000_0000_1234, 2'd1, 1'b1, 1'b1, 1'b0);
      send(64'hFFFF_0000_0000_1234, 2'd1, 1'b1, 1'b1, 1'b0);
      send(64'h0000_0000_0000_0000, 2'd0, 1'b1, 1'b0, 1'b1);
      // varying registers and addresses
      for (int i = 0; i < 400; i++) begin
         part_reg = 12'($urandom); proc_reg = 20'($urandom);
         rmo_reg = {$urandom, $urandom};
         send({$urandom, $urandom}, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
         if (i % 5 == 0) repeat (2) @(posedge clk);
         #1;
      end
      repeat (3) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule